// File: doc/BRIEF.md
# DSP Instruction Word Decoder

This block is a purely combinational classifier for the 16-bit instruction words of an accumulator-based DSP. The fetch stage presents each program word together with a flag saying whether the word opens an instruction or is the extension word of the previous one. From the 7-bit class field in the top bits of an opening word, the decoder derives these outputs:

- an operation kind;
- an ALU operation code;
- an operand addressing mode;
- a request for a second program word, which carries an immediate operand or a branch target.

It also cuts out the register, pointer, direct-address and short-immediate fields, so that the execute stage needs no knowledge of the bit layout.

The operation and the operand mode share one packed class field. The top three class bits choose the ALU function, and the low nibble chooses where the operand comes from. The pointer register number is put together from bits of the word that are not adjacent. A one-hot class vector and an illegal-class flag are also provided, so that a checker or a bench can see which class was recognised. Classes the decoder does not know are executed as no-operations.

Top module: `dsp_insn_decoder`

## Requirements
- R1: The class is bits 15:9 of the word. `class_hot_o` has bit c set exactly when `first_word_i` is 1, the class equals c and c is a recognised class. In every other case the vector is all zero.
- R2: `dst_o` is always bits 7:4 and `src_o` is always bits 3:0. The word 0x0000 as a first word gives kind 0 (no-operation), even though its class 0x00 is recognised.
- R3: `need_ext_o` is 1 for first words of classes 0x04, 0x06, 0x24, 0x26, 0x14, 0x34, 0x44, 0x54, 0x64 and 0x74. It is 0 for every other word.
- R4: `ram_addr_o` is always bits 8:0 and `short_imm_o` is always bits 7:0.
- R5: For classes 0x0C to 0x0F, `ptr_idx_o` is bits 10:8. For all other classes it is {bit 8, bit 1, bit 0}, with bit 8 as the top bit.
- R6: `alu_op_o` takes these values for ALU classes:

  | Upper class bits | Operation | `alu_op_o` |
  |---|---|---|
  | 001 | subtract | 1 |
  | 011 | compare | 3 |
  | 100 | add | 4 |
  | 101 | AND | 5 |
  | 110 | OR | 6 |
  | 111 | XOR | 7 |

  Class 0x03 (load accumulator from direct RAM) gives 2. All other words give 0.
- R7: A class is an ALU class when its upper three bits are one of 001, 011, 100, 101, 110 or 111 and its low nibble is one of 0, 1, 3, 4, 5, 9 or 0xC. For ALU classes and for class 0x03, `amode_o` is the low nibble of the class. It is 0 for every other word.
- R8: Class 0x24 gives kind 3 (conditional call) and class 0x26 gives kind 4 (conditional branch). Both request an extension word.
- R9: A first word whose class is not recognised gives kind 0 and `illegal_o`=1. For such a word `class_hot_o`, `need_ext_o`, `alu_op_o` and `amode_o` are all zero.
- R10: When `first_word_i` is 0, the outputs are forced as follows: kind 0, `illegal_o`=0, `class_hot_o`=0, `need_ext_o`=0, `alu_op_o`=0 and `amode_o`=0. The field outputs are still extracted.
- R11: The kind codes are:
  - kind 1 (data move) for non-zero words of class 0x00 and for classes 0x01, 0x02, 0x04, 0x05, 0x06, 0x07, 0x09, 0x0A and 0x25;
  - kind 5 (pointer load with short immediate) for classes 0x0C to 0x0F;
  - kind 2 for ALU classes and for class 0x03.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 16 | Fetched program word |
| first_word_i | input | 1 | 1 when the word opens an instruction |
| kind_o | output | 3 | Operation kind code |
| alu_op_o | output | 3 | ALU operation code |
| amode_o | output | 4 | Operand addressing mode |
| dst_o | output | 4 | Destination register field |
| src_o | output | 4 | Source register field |
| ptr_idx_o | output | 3 | Pointer register index |
| ram_addr_o | output | 9 | Direct RAM address |
| short_imm_o | output | 8 | Short immediate value |
| need_ext_o | output | 1 | An extension word must be fetched |
| class_hot_o | output | 128 | One-hot recognised class |
| illegal_o | output | 1 | Unrecognised class in a first word |

## Verification
The embedded checks assume that the instruction word and the first-word flag carry known values. Each check is therefore gated until neither input holds an unknown bit. The checks also assume that the outputs are read only after the inputs have settled, because the block holds no state. The bench drives every one of the 65,536 words with the flag set and again with it clear, changing inputs only between samples. This covers every recognised and unrecognised class, and both ways of forming the pointer index.

// File: rtl/dspdec_pkg.sv
package dspdec_pkg;

   localparam int CLS_W = 7;

   typedef enum logic [2:0] {
      KIND_NOP    = 3'd0,
      KIND_MOVE   = 3'd1,
      KIND_ALU    = 3'd2,
      KIND_CALL   = 3'd3,
      KIND_BRANCH = 3'd4,
      KIND_PTRSET = 3'd5
   } kind_e;

   typedef enum logic [2:0] {
      AOP_NONE = 3'd0,
      AOP_SUB  = 3'd1,
      AOP_LDA  = 3'd2,
      AOP_CMP  = 3'd3,
      AOP_ADD  = 3'd4,
      AOP_AND  = 3'd5,
      AOP_OR   = 3'd6,
      AOP_XOR  = 3'd7
   } alu_op_e;

   // operand source selected by the low class nibble
   function automatic logic mode_ok(input logic [3:0] m);
      case (m)
         4'h0, 4'h1, 4'h3, 4'h4, 4'h5, 4'h9, 4'hC: mode_ok = 1'b1;
         default:                                  mode_ok = 1'b0;
      endcase
   endfunction

   function automatic logic is_alu_class(input logic [CLS_W-1:0] c);
      is_alu_class = (c[6:4] != 3'b000) && (c[6:4] != 3'b010) && mode_ok(c[3:0]);
   endfunction

   function automatic logic is_move_class(input logic [CLS_W-1:0] c);
      case (c)
         7'h00, 7'h01, 7'h02, 7'h04, 7'h05, 7'h06,
         7'h07, 7'h09, 7'h0A, 7'h25: is_move_class = 1'b1;
         default:                    is_move_class = 1'b0;
      endcase
   endfunction

   function automatic logic is_ptrset_class(input logic [CLS_W-1:0] c);
      is_ptrset_class = (c[6:2] == 5'b00011);
   endfunction

   function automatic logic is_known_class(input logic [CLS_W-1:0] c);
      is_known_class = is_alu_class(c) || is_move_class(c) || is_ptrset_class(c)
                       || (c == 7'h03) || (c == 7'h24) || (c == 7'h26);
   endfunction

   function automatic logic class_needs_ext(input logic [CLS_W-1:0] c);
      class_needs_ext = (c == 7'h04) || (c == 7'h06) || (c == 7'h24) || (c == 7'h26)
                        || (is_alu_class(c) && (c[3:0] == 4'h4));
   endfunction

endpackage

// File: rtl/dspdec_class_sel.sv
module dspdec_class_sel
   import dspdec_pkg::*;
#(
   parameter int CLASS_W = 7,
   localparam int NCLS   = 1 << CLASS_W
) (
   input  logic [CLASS_W-1:0] cls_i,
   input  logic               valid_i,
   output logic [NCLS-1:0]    hot_o,
   output logic               known_o,
   output logic               ext_o
);

   if (CLASS_W != CLS_W) begin : g_bad_cls
      $error("class width must match the encoding width");
   end

   // one comparator per class; unknown classes are tied off at elaboration
   for (genvar c = 0; c < NCLS; c++) begin : g_hot
      localparam logic [CLASS_W-1:0] CV = CLASS_W'(c);
      if (is_known_class(CV)) begin : g_known
         assign hot_o[c] = valid_i && (cls_i == CV);
      end else begin : g_unknown
         assign hot_o[c] = 1'b0;
      end
   end

   assign known_o = |hot_o;
   assign ext_o   = valid_i && class_needs_ext(cls_i);

   always_comb begin
      if (!$isunknown({cls_i, valid_i})) begin
         // R3
         ext_needs_known_chk: assert (!ext_o || known_o);
      end
   end

endmodule

// File: rtl/dspdec_alu_sel.sv
module dspdec_alu_sel
   import dspdec_pkg::*;
#(
   parameter int CLASS_W = 7,
   parameter int MODE_W  = 4
) (
   input  logic [CLASS_W-1:0] cls_i,
   input  logic               valid_i,
   output logic               is_alu_o,
   output logic [2:0]         alu_op_o,
   output logic [MODE_W-1:0]  amode_o
);

   if (MODE_W != 4) begin : g_bad_mode
      $error("mode field must be one nibble");
   end

   logic alu_c;
   logic lda_c;

   always_comb begin
      alu_c    = valid_i && is_alu_class(cls_i);
      lda_c    = valid_i && (cls_i == 7'h03);
      is_alu_o = alu_c || lda_c;
      alu_op_o = AOP_NONE;
      amode_o  = '0;
      if (alu_c) begin
         alu_op_o = cls_i[CLASS_W-1 -: 3];
         amode_o  = cls_i[MODE_W-1:0];
      end else if (lda_c) begin
         alu_op_o = AOP_LDA;
         amode_o  = 4'h3;
      end
   end

   always_comb begin
      if (!$isunknown({cls_i, valid_i})) begin
         // R6
         alu_op_idle_chk: assert (is_alu_o || (alu_op_o == 3'd0 && amode_o == '0));
      end
   end

endmodule

// File: rtl/dspdec_field_ext.sv
module dspdec_field_ext #(
   parameter int WORD_W = 16,
   parameter int REG_W  = 4,
   parameter int PTR_W  = 3,
   parameter int DIR_W  = 9,
   parameter int SIMM_W = 8
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic              ptrset_i,
   output logic [REG_W-1:0]  dst_o,
   output logic [REG_W-1:0]  src_o,
   output logic [PTR_W-1:0]  ptr_o,
   output logic [DIR_W-1:0]  dir_o,
   output logic [SIMM_W-1:0] simm_o
);

   localparam int PTR_LO_W = PTR_W - 1;
   localparam int PTR_HI_B = DIR_W - 1;

   if (2 * REG_W > WORD_W || DIR_W >= WORD_W || SIMM_W > DIR_W) begin : g_bad_fields
      $error("field widths do not fit the instruction word");
   end

   assign dst_o  = word_i[2*REG_W-1 -: REG_W];
   assign src_o  = word_i[REG_W-1:0];
   assign dir_o  = word_i[DIR_W-1:0];
   assign simm_o = word_i[SIMM_W-1:0];

   // pointer index: split form {bit 8, bits 1:0} or contiguous form bits 10:8
   logic [PTR_W-1:0] ptr_split;
   logic [PTR_W-1:0] ptr_flat;
   assign ptr_split = {word_i[PTR_HI_B], word_i[PTR_LO_W-1:0]};
   assign ptr_flat  = word_i[PTR_HI_B + PTR_W - 1 -: PTR_W];
   assign ptr_o     = ptrset_i ? ptr_flat : ptr_split;

   always_comb begin
      if (!$isunknown({word_i, ptrset_i})) begin
         // R5
         ptr_top_bit_chk: assert (ptr_o[PTR_W-1] == word_i[PTR_HI_B + (ptrset_i ? PTR_W-1 : 0)]);
      end
   end

endmodule

// File: rtl/dsp_insn_decoder.sv
module dsp_insn_decoder
   import dspdec_pkg::*;
#(
   parameter int WORD_W  = 16,
   parameter int CLASS_W = 7,
   parameter int REG_W   = 4,
   parameter int PTR_W   = 3,
   parameter int DIR_W   = 9,
   parameter int SIMM_W  = 8,
   parameter int MODE_W  = 4,
   localparam int NCLS   = 1 << CLASS_W
) (
   input  logic [WORD_W-1:0] insn_i,
   input  logic              first_word_i,
   output logic [2:0]        kind_o,
   output logic [2:0]        alu_op_o,
   output logic [MODE_W-1:0] amode_o,
   output logic [REG_W-1:0]  dst_o,
   output logic [REG_W-1:0]  src_o,
   output logic [PTR_W-1:0]  ptr_idx_o,
   output logic [DIR_W-1:0]  ram_addr_o,
   output logic [SIMM_W-1:0] short_imm_o,
   output logic              need_ext_o,
   output logic [NCLS-1:0]   class_hot_o,
   output logic              illegal_o
);

   if (WORD_W != 16) begin : g_bad_word
      $error("instruction word must be 16 bits");
   end

   logic [CLASS_W-1:0] cls;
   logic               known;
   logic               is_alu;
   logic               ptrset;
   kind_e              kind;

   assign cls    = insn_i[WORD_W-1 -: CLASS_W];
   assign ptrset = is_ptrset_class(cls);

   dspdec_class_sel #(.CLASS_W(CLASS_W)) u_class (
      .cls_i   (cls),
      .valid_i (first_word_i),
      .hot_o   (class_hot_o),
      .known_o (known),
      .ext_o   (need_ext_o)
   );

   dspdec_alu_sel #(.CLASS_W(CLASS_W), .MODE_W(MODE_W)) u_alu (
      .cls_i    (cls),
      .valid_i  (first_word_i),
      .is_alu_o (is_alu),
      .alu_op_o (alu_op_o),
      .amode_o  (amode_o)
   );

   dspdec_field_ext #(
      .WORD_W (WORD_W), .REG_W (REG_W), .PTR_W (PTR_W),
      .DIR_W  (DIR_W),  .SIMM_W(SIMM_W)
   ) u_fields (
      .word_i   (insn_i),
      .ptrset_i (ptrset),
      .dst_o    (dst_o),
      .src_o    (src_o),
      .ptr_o    (ptr_idx_o),
      .dir_o    (ram_addr_o),
      .simm_o   (short_imm_o)
   );

   always_comb begin
      kind = KIND_NOP;
      if (first_word_i && known) begin
         if (is_alu)                        kind = KIND_ALU;
         else if (ptrset)                   kind = KIND_PTRSET;
         else if (cls == 7'h24)             kind = KIND_CALL;
         else if (cls == 7'h26)             kind = KIND_BRANCH;
         else if (insn_i != '0)             kind = KIND_MOVE;
      end
   end

   assign kind_o    = kind;
   assign illegal_o = first_word_i && !known;

   always_comb begin
      if (!$isunknown({insn_i, first_word_i})) begin
         // R1
         class_onehot_chk: assert ($onehot0(class_hot_o));
         // R9
         illegal_quiet_chk: assert (!illegal_o || (kind_o == 3'd0 && !need_ext_o && alu_op_o == 3'd0));
         // R10
         ext_word_quiet_chk: assert (first_word_i || (!illegal_o && !need_ext_o && kind_o == 3'd0));
         // R8
         branch_ext_chk: assert (!(kind_o == 3'd3 || kind_o == 3'd4) || need_ext_o);
      end
   end

endmodule

// File: tb/dsp_insn_decoder_bench.sv
module dsp_insn_decoder_bench;

   logic        clk = 1'b0;
   logic [15:0] insn;
   logic        first;
   logic [2:0]  kind, aop;
   logic [3:0]  amode, dst, src;
   logic [2:0]  ptr;
   logic [8:0]  ram;
   logic [7:0]  simm;
   logic        ext, ill;
   logic [127:0] hot;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   dsp_insn_decoder u_dsp_insn_decoder (
      .insn_i(insn), .first_word_i(first), .kind_o(kind), .alu_op_o(aop),
      .amode_o(amode), .dst_o(dst), .src_o(src), .ptr_idx_o(ptr),
      .ram_addr_o(ram), .short_imm_o(simm), .need_ext_o(ext),
      .class_hot_o(hot), .illegal_o(ill)
   );

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s word=%h first=%0b actual=%h expected=%h", tag, insn, first, act, exp);
      end
   endtask

   // reference classification built from the requirement lists
   function automatic bit ref_alu(input int c);
      int up = c / 16;
      int lo = c % 16;
      bit mok = (lo == 0) || (lo == 1) || (lo == 3) || (lo == 4) || (lo == 5) || (lo == 9) || (lo == 12);
      return mok && (up == 1 || up == 3 || up == 4 || up == 5 || up == 6 || up == 7);
   endfunction

   function automatic bit ref_move(input int c);
      return c == 0 || c == 1 || c == 2 || c == 4 || c == 5 || c == 6 ||
             c == 7 || c == 9 || c == 10 || c == 37;
   endfunction

   task automatic check_vector(input int w, input bit f);
      int  c      = w / 512;
      bit  alu    = ref_alu(c);
      bit  lda    = (c == 3);
      bit  pset   = (c >= 12 && c <= 15);
      bit  known  = alu || lda || pset || ref_move(c) || c == 36 || c == 38;
      int  ekind  = 0;
      int  eaop   = 0;
      int  emode  = 0;
      int  eptr;
      bit  eext   = 0;
      logic [127:0] ehot = '0;
      if (f && known) begin
         ehot[c] = 1'b1;
         if (alu || lda)        ekind = 2;
         else if (pset)         ekind = 5;
         else if (c == 36)      ekind = 3;
         else if (c == 38)      ekind = 4;
         else if (w != 0)       ekind = 1;
         if (alu) begin
            eaop  = c / 16;
            emode = c % 16;
         end else if (lda) begin
            eaop  = 2;
            emode = 3;
         end
         eext = (c == 4) || (c == 6) || (c == 36) || (c == 38) || (alu && (c % 16) == 4);
      end
      eptr = pset ? (w / 256) % 8 : ((w / 256) % 2) * 4 + (w % 4);

      if (!f) begin
         chk("R10 kind", kind, 0);
         chk("R10 illegal", ill, 0);
         chk("R10 hot", hot, 0);
         chk("R10 ext", ext, 0);
         chk("R10 aop", {aop, amode}, 0);
      end else if (!known) begin
         chk("R9 kind", kind, 0);
         chk("R9 illegal", ill, 1);
         chk("R9 hot", hot, 0);
         chk("R9 ext", ext, 0);
         chk("R9 aop", {aop, amode}, 0);
      end else begin
         chk("R1 hot", hot, ehot);
         chk("R1 illegal", ill, 0);
         if (c == 36 || c == 38) chk("R8 kind", kind, ekind);
         else if (w == 0)        chk("R2 nop kind", kind, 0);
         else                    chk("R11 kind", kind, ekind);
         chk("R3 ext", ext, eext);
         chk("R6 aop", aop, eaop);
         chk("R7 amode", amode, emode);
      end
      chk("R2 dst", dst, (w / 16) % 16);
      chk("R2 src", src, w % 16);
      chk("R4 ram", ram, w % 512);
      chk("R4 simm", simm, w % 256);
      chk("R5 ptr", ptr, eptr);
   endtask

   initial begin
      insn  = '0;
      first = 1'b1;
      #1;
      chk("R2 reset-state nop", {kind, ill, ext}, 0);
      for (int fl = 1; fl >= 0; fl--) begin
         for (int w = 0; w < 65536; w++) begin
            if (done) break;
            insn  = 16'(w);
            first = fl[0];
            #0.5;
            check_vector(w, fl[0]);
            #0.5;
         end
      end
      done = 1;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000 && !done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected<190000", cycles);
         done = 1;
      end
   end

   initial begin
      wait (done);
      #3;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule